// File: doc/BRIEF.md
# Erase-block decoder with protection gating and identification reads

This unit sits beside the command sequencer of a byte-wide flash controller. It turns an 18-bit byte address into the index of one of seven erase blocks of unequal size. The boot end of the map, which is the top or the bottom of the address space, is chosen by a parameter. The unit keeps one protection flag per block, and firmware or test logic sets or clears a flag by pulsing a strobe with an address inside the block.

While the identification flag is high, the read-data output carries one of four things, chosen by the two lowest address bits: the maker code, the part code (which depends on the boot end), the protection state of the addressed block, or zero.

The sequencer presents program and erase requests to the unit. The unit passes on a program only when its block may be changed. For an erase, it narrows the requested block mask to the blocks that may be changed. When nothing is left in the mask, the unit raises a flag so that the sequencer can finish the erase without touching the array and without reporting an error. An override input lifts every protection flag for as long as it is held.

All outputs are registered and follow their inputs by one clock.

Top module: `idprot_unit`

## Requirements
- R1: With BOOT_TOP=1, blk_idx counts upward with address: index 0, 1 and 2 are the 64 KB blocks at 00000h, 10000h and 20000h, index 3 is the 32 KB block at 30000h, index 4 and 5 are the 8 KB blocks at 38000h and 3A000h, and index 6 is the 16 KB block at 3C000h.
- R2: With BOOT_TOP=0, index 0 is the 16 KB block at 00000h, index 1 and 2 are the 8 KB blocks at 04000h and 06000h, index 3 is the 32 KB block at 08000h, and index 4, 5 and 6 are the 64 KB blocks at 10000h, 20000h and 30000h.
- R3: With id_mode high and addr[1:0]=00, id_data is 20h.
- R4: With id_mode high and addr[1:0]=01, id_data is B0h when BOOT_TOP=1 and 34h when BOOT_TOP=0.
- R5: With id_mode high and addr[1:0]=10, id_data is 01h if the block that holds addr is protected and 00h if it is not.
- R6: With id_mode high and addr[1:0]=11, id_data is 00h. With id_mode low, id_data is always 00h.
- R7: After reset every block is unprotected, and all outputs are zero.
- R8: A prot_set pulse protects the addressed block and a prot_clr pulse unprotects it. When both are high in the same cycle, prot_set wins. No other input changes a protection flag. The new state shows from the cycle after the strobe.
- R9: A prog_req to a protected block, with unprot_ovr low, gives prog_ok low. This is the only sign that the write was dropped. A prog_req to an unprotected block gives prog_ok high.
- R10: With erase_req high, erase_mask equals erase_sel with the bits of protected blocks cleared. With erase_req low, erase_mask is zero.
- R11: erase_none is high when erase_req is high and the resulting erase_mask is zero. This covers a full-chip request when every block is protected.
- R12: While unprot_ovr is high, prog_ok equals prog_req, and erase_mask equals erase_sel during erase_req, whatever the protection flags hold.
- R13: Every output reflects the inputs and protection state of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 18 | Byte address |
| id_mode | input | 1 | Identification reads enabled |
| prot_set | input | 1 | Protect the block holding addr |
| prot_clr | input | 1 | Unprotect the block holding addr |
| unprot_ovr | input | 1 | Temporary override of all protection |
| prog_req | input | 1 | Program request at addr |
| erase_req | input | 1 | Erase request for the blocks in erase_sel |
| erase_sel | input | 7 | Requested blocks, one bit per block index |
| blk_idx | output | 3 | Block index of addr |
| id_data | output | 8 | Identification read data |
| prog_ok | output | 1 | Program allowed |
| erase_mask | output | 7 | Blocks that may be erased |
| erase_none | output | 1 | Erase request left with no block to erase |

## Verification
The embedded properties check on every cycle:
- a protected program is dropped;
- the override forces a program through;
- no protected bit survives into the erase mask;
- the all-protected erase is flagged;
- the maker code and the idle zero appear on the identification output;
- protection flags stay still without a strobe, and set wins over clear.

The following only show in the bench's sweeps, which compare against a model of both boot ends:
- the exact block boundaries;
- the part code for each boot end;
- the status read after each set and clear;
- the reset state;
- the full range of erase masks.

// File: rtl/idprot_pkg.sv
package idprot_pkg;
  // identification read selector, taken from addr[1:0]
  typedef enum logic [1:0] {
    SEL_MAKER = 2'b00,
    SEL_PART  = 2'b01,
    SEL_LOCK  = 2'b10,
    SEL_RSVD  = 2'b11
  } id_sel_e;

  localparam int LARGE_SHIFT = 16;  // log2 of the large block size
  localparam int SUB_SHIFT   = 13;  // log2 of the smallest block size
  localparam int NUM_SMALL   = 3;   // extra blocks carved from the boot end
endpackage

// File: rtl/idprot_blkdec.sv
module idprot_blkdec #(
  parameter int ADDR_W   = 18,
  parameter bit BOOT_TOP = 1'b1,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-idprot_pkg::SUB_SHIFT-1:0] addr_hi,
  output logic [IDX_W-1:0]                       idx
);
  import idprot_pkg::*;
  localparam int HI_W  = ADDR_W - LARGE_SHIFT;
  localparam int NMAIN = (1 << HI_W) - 1;
  localparam int SUB_W = LARGE_SHIFT - SUB_SHIFT;

  logic [HI_W-1:0]  hi;
  logic [SUB_W-1:0] sub;
  assign hi  = addr_hi[ADDR_W-SUB_SHIFT-1:SUB_W];
  assign sub = addr_hi[SUB_W-1:0];

  generate
    if (BOOT_TOP) begin : g_top
      always_comb begin
        if (hi != {HI_W{1'b1}})       idx = IDX_W'(hi);
        else if (!sub[SUB_W-1])       idx = IDX_W'(NMAIN);
        else if (sub == SUB_W'(4))    idx = IDX_W'(NMAIN + 1);
        else if (sub == SUB_W'(5))    idx = IDX_W'(NMAIN + 2);
        else                          idx = IDX_W'(NMAIN + 3);
      end
    end else begin : g_bot
      always_comb begin
        if (hi != '0)                 idx = IDX_W'(hi) + IDX_W'(NUM_SMALL);
        else if (sub[SUB_W-1])        idx = IDX_W'(3);
        else if (sub == SUB_W'(3))    idx = IDX_W'(2);
        else if (sub == SUB_W'(2))    idx = IDX_W'(1);
        else                          idx = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/idprot_store.sv
module idprot_store #(
  parameter int NUM_BLK = 7,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_BLK-1:0] prot_q
);
  generate
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)                                  prot_q[g] <= 1'b0;
        else if (set_i && idx == IDX_W'(g))       prot_q[g] <= 1'b1;
        else if (clr_i && idx == IDX_W'(g))       prot_q[g] <= 1'b0;
      end
    end
  endgenerate

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(prot_q));
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i && idx < IDX_W'(NUM_BLK)) |=> prot_q[$past(idx)]);
endmodule

// File: rtl/idprot_idmux.sv
module idprot_idmux #(
  parameter logic [7:0] MAKER = 8'h20,
  parameter logic [7:0] PART  = 8'hB0
) (
  input  logic       id_mode,
  input  logic [1:0] sel,
  input  logic       lock_bit,
  output logic [7:0] data
);
  import idprot_pkg::*;
  always_comb begin
    data = 8'h00;
    if (id_mode) begin
      unique case (id_sel_e'(sel))
        SEL_MAKER: data = MAKER;
        SEL_PART:  data = PART;
        SEL_LOCK:  data = {7'b0, lock_bit};
        SEL_RSVD:  data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/idprot_unit.sv
module idprot_unit #(
  parameter int         ADDR_W       = 18,
  parameter bit         BOOT_TOP     = 1'b1,
  parameter logic [7:0] MAKER_CODE   = 8'h20,
  parameter logic [7:0] PART_TOP     = 8'hB0,
  parameter logic [7:0] PART_BOT     = 8'h34,
  parameter int         NUM_BLK      = (1 << (ADDR_W - 16)) + 3,
  parameter int         IDX_W        = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               id_mode,
  input  logic               prot_set,
  input  logic               prot_clr,
  input  logic               unprot_ovr,
  input  logic               prog_req,
  input  logic               erase_req,
  input  logic [NUM_BLK-1:0] erase_sel,
  output logic [IDX_W-1:0]   blk_idx,
  output logic [7:0]         id_data,
  output logic               prog_ok,
  output logic [NUM_BLK-1:0] erase_mask,
  output logic               erase_none
);
  import idprot_pkg::*;
  localparam logic [7:0] PART_CODE = BOOT_TOP ? PART_TOP : PART_BOT;

  logic [IDX_W-1:0]   idx_c;
  logic [NUM_BLK-1:0] prot_q;
  logic [NUM_BLK-1:0] allow_c;
  logic [NUM_BLK-1:0] mask_c;
  logic [7:0]         id_c;
  logic               lock_c;
  logic               unused_addr_bits;

  assign unused_addr_bits = ^addr[SUB_SHIFT-1:2];

  idprot_blkdec #(.ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP), .IDX_W(IDX_W)) u_dec (
    .addr_hi (addr[ADDR_W-1:SUB_SHIFT]),
    .idx     (idx_c)
  );

  idprot_store #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .set_i  (prot_set),
    .clr_i  (prot_clr),
    .idx    (idx_c),
    .prot_q (prot_q)
  );

  assign lock_c = prot_q[idx_c];

  idprot_idmux #(.MAKER(MAKER_CODE), .PART(PART_CODE)) u_mux (
    .id_mode  (id_mode),
    .sel      (addr[1:0]),
    .lock_bit (lock_c),
    .data     (id_c)
  );

  assign allow_c = unprot_ovr ? {NUM_BLK{1'b1}} : ~prot_q;
  assign mask_c  = erase_req ? (erase_sel & allow_c) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_idx    <= '0;
      id_data    <= 8'h00;
      prog_ok    <= 1'b0;
      erase_mask <= '0;
      erase_none <= 1'b0;
    end else begin
      blk_idx    <= idx_c;
      id_data    <= id_c;
      prog_ok    <= prog_req & allow_c[idx_c];
      erase_mask <= mask_c;
      erase_none <= erase_req & (mask_c == '0);
    end
  end

  // R9
  prog_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_req && !unprot_ovr && prot_q[idx_c]) |=> !prog_ok);
  // R12
  ovr_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_req && unprot_ovr) |=> prog_ok);
  // R10
  erase_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (erase_req && !unprot_ovr) |=> ((erase_mask & $past(prot_q)) == '0));
  // R11
  erase_none_chk: assert property (@(posedge clk) disable iff (rst)
    (erase_req && !unprot_ovr && (&prot_q)) |=> erase_none);
  // R6
  id_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !id_mode |=> (id_data == 8'h00));
  // R3
  maker_chk: assert property (@(posedge clk) disable iff (rst)
    (id_mode && addr[1:0] == 2'b00) |=> (id_data == MAKER_CODE));
endmodule

// File: tb/idprot_unit_tb.sv
module idprot_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] addr = '0;
  logic        id_mode = 1'b0, prot_set = 1'b0, prot_clr = 1'b0;
  logic        unprot_ovr = 1'b0, prog_req = 1'b0, erase_req = 1'b0;
  logic [6:0]  erase_sel = '0;

  logic [2:0] idx_t, idx_b;
  logic [7:0] id_t, id_b;
  logic       pok_t, pok_b, none_t, none_b;
  logic [6:0] msk_t, msk_b;

  int checks = 0;
  int errors = 0;
  logic [6:0] pt = '0;
  logic [6:0] pb = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  idprot_unit #(.BOOT_TOP(1'b1)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .id_mode(id_mode), .prot_set(prot_set),
    .prot_clr(prot_clr), .unprot_ovr(unprot_ovr), .prog_req(prog_req),
    .erase_req(erase_req), .erase_sel(erase_sel), .blk_idx(idx_t), .id_data(id_t),
    .prog_ok(pok_t), .erase_mask(msk_t), .erase_none(none_t));

  idprot_unit #(.BOOT_TOP(1'b0)) u_dut_bb (
    .clk(clk), .rst(rst), .addr(addr), .id_mode(id_mode), .prot_set(prot_set),
    .prot_clr(prot_clr), .unprot_ovr(unprot_ovr), .prog_req(prog_req),
    .erase_req(erase_req), .erase_sel(erase_sel), .blk_idx(idx_b), .id_data(id_b),
    .prog_ok(pok_b), .erase_mask(msk_b), .erase_none(none_b));

  function automatic int ref_idx(bit top, logic [17:0] a);
    int hi;
    hi = int'(a[17:16]);
    if (top) begin
      if (hi < 3) return hi;
      if (a < 18'h38000) return 3;
      if (a < 18'h3A000) return 4;
      if (a < 18'h3C000) return 5;
      return 6;
    end
    if (hi > 0) return hi + 3;
    if (a >= 18'h08000) return 3;
    if (a >= 18'h06000) return 2;
    if (a >= 18'h04000) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: model the expected outputs, update model, sample at next negedge
  task automatic tick(string tag);
    int ei_t, ei_b, ed_t, ed_b, ep_t, ep_b, em_t, em_b;
    logic [6:0] al_t, al_b;
    ei_t = ref_idx(1'b1, addr);
    ei_b = ref_idx(1'b0, addr);
    al_t = unprot_ovr ? 7'h7f : ~pt;
    al_b = unprot_ovr ? 7'h7f : ~pb;
    ed_t = 0; ed_b = 0;
    if (id_mode) begin
      case (addr[1:0])
        2'b00: begin ed_t = 'h20; ed_b = 'h20; end
        2'b01: begin ed_t = 'hB0; ed_b = 'h34; end
        2'b10: begin ed_t = int'(pt[ei_t]); ed_b = int'(pb[ei_b]); end
        default: begin ed_t = 0; ed_b = 0; end
      endcase
    end
    ep_t = int'(prog_req & al_t[ei_t]);
    ep_b = int'(prog_req & al_b[ei_b]);
    em_t = erase_req ? int'(erase_sel & al_t) : 0;
    em_b = erase_req ? int'(erase_sel & al_b) : 0;
    if (prot_set)      begin pt[ei_t] = 1'b1; pb[ei_b] = 1'b1; end
    else if (prot_clr) begin pt[ei_t] = 1'b0; pb[ei_b] = 1'b0; end
    @(negedge clk);
    chk(tag, "idx top",   int'(idx_t), ei_t);
    chk(tag, "idx bot",   int'(idx_b), ei_b);
    chk(tag, "id top",    int'(id_t),  ed_t);
    chk(tag, "id bot",    int'(id_b),  ed_b);
    chk(tag, "prog top",  int'(pok_t), ep_t);
    chk(tag, "prog bot",  int'(pok_b), ep_b);
    chk(tag, "mask top",  int'(msk_t), em_t);
    chk(tag, "mask bot",  int'(msk_b), em_b);
    chk(tag, "none top",  int'(none_t), int'(erase_req && em_t == 0));
    chk(tag, "none bot",  int'(none_b), int'(erase_req && em_b == 0));
  endtask

  task automatic apply(logic [17:0] a, logic idm, logic ps, logic pc, logic ov,
                       logic pr, logic er, logic [6:0] sel, string tag);
    addr = a; id_mode = idm; prot_set = ps; prot_clr = pc;
    unprot_ovr = ov; prog_req = pr; erase_req = er; erase_sel = sel;
    tick(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7 reset state of every output
    chk("R7", "reset idx",  int'(idx_t) + int'(idx_b), 0);
    chk("R7", "reset id",   int'(id_t) + int'(id_b), 0);
    chk("R7", "reset misc", int'(pok_t) + int'(pok_b) + int'(msk_t) + int'(msk_b)
                            + int'(none_t) + int'(none_b), 0);
    // R7 / R5: every block reads unprotected after reset
    for (int i = 0; i < 128; i++) apply(18'(i * 2048 + 2), 1'b1, 0, 0, 0, 0, 0, 0, "R7 R5 lock");
    // R1 R2 R3 R4 R6 R13: map sweep with all id selectors and id_mode toggling
    for (int i = 0; i < 1024; i++)
      apply(18'(i * 256 + (i % 4)), (i % 8) < 6, 0, 0, 0, 0, 0, 0, "R1 R2 R3 R4 R6 R13");
    // R1 R2 boundary pairs
    for (int i = 1; i < 32; i++) begin
      apply(18'(i * 8192 - 1), 1'b0, 0, 0, 0, 0, 0, 0, "R1 R2 edge");
      apply(18'(i * 8192),     1'b0, 0, 0, 0, 0, 0, 0, "R1 R2 edge");
    end
    // R8 set strobes, then status reads
    apply(18'h3C000, 1'b0, 1, 0, 0, 0, 0, 0, "R8 set");
    apply(18'h08000, 1'b0, 1, 0, 0, 0, 0, 0, "R8 set");
    apply(18'h04000, 1'b0, 1, 0, 0, 0, 0, 0, "R8 set");
    for (int i = 0; i < 128; i++) apply(18'(i * 2048 + 2), 1'b1, 0, 0, 0, 0, 0, 0, "R5 R8");
    apply(18'h3A000, 1'b0, 1, 1, 0, 0, 0, 0, "R8 set priority");
    apply(18'h3C000, 1'b0, 0, 1, 0, 0, 0, 0, "R8 clear");
    for (int i = 0; i < 128; i++) apply(18'(i * 2048 + 2), 1'b1, 0, 0, 0, 0, 0, 0, "R5 R8 after");
    // R9 program gating, R12 with override
    for (int i = 0; i < 64; i++) apply(18'(i * 4096 + 5), 1'b0, 0, 0, 0, 1, 0, 0, "R9 prog");
    for (int i = 0; i < 64; i++) apply(18'(i * 4096 + 5), 1'b0, 0, 0, 1, 1, 0, 0, "R12 prog");
    // R10 every erase mask
    for (int i = 0; i < 128; i++) apply(18'h0, 1'b0, 0, 0, 0, 0, 1, 7'(i), "R10 erase");
    for (int i = 0; i < 32; i++) apply(18'(i * 8192), 1'b0, 0, 0, 0, 0, 0, 7'(i), "R10 idle");
    // R11 every block protected, full-chip erase
    for (int i = 0; i < 32; i++) apply(18'(i * 8192), 1'b0, 1, 0, 0, 0, 0, 0, "R11 lock all");
    apply(18'h0, 1'b0, 0, 0, 0, 0, 1, 7'h7f, "R11 erase none");
    apply(18'h0, 1'b0, 0, 0, 0, 1, 1, 7'h7f, "R11 R9 all locked");
    // R12 override on a fully protected part
    for (int i = 0; i < 128; i++) apply(18'h12345, 1'b0, 0, 0, 1, 1, 1, 7'(i), "R12 erase");
    apply(18'h0, 1'b1, 0, 0, 0, 0, 0, 0, "R13 settle");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule